// File: doc/BRIEF.md
# CAN Fault-Confinement Counters with Test Overrides

This block holds the two fault-confinement counters of a CAN node: the transmit error count and the receive error count. From them it derives the node's error state, which is one of error active, error passive or bus-off. A protocol engine reports what happened on the bus through single-cycle event pulses: transmit error, transmit success, receive error and receive success. The block applies fixed step sizes to those events. It also raises a warning flag when either counter climbs high. Leaving bus-off takes an external recovery pulse.

A 16-bit test-control word is written through a small register port. A master enable bit gates three overrides. The first freezes both counters. The second forces the node to report error passive. The third loads one 8-bit value into both counters in the same cycle, and it works only while the controller is halted. The same register port carries that counter load when its select input is high.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, both counters are 0, the test-control word reads 0x0000, and only `err_active_o` is set.
- R2: A transmit-error pulse adds 8 to the transmit counter. A transmit-success pulse subtracts 1, but never below 0. If both pulses arrive in the same cycle, the error wins.
- R3: A receive-error pulse adds 1 to the receive counter, which saturates at 255 and never wraps. A receive-success pulse subtracts 1, but never below 0. If both arrive together, the error wins.
- R4: The node is error passive when either counter is 128 or more, and error active otherwise. `warn_o` is high when either counter is 96 or more.
- R5: A transmit error that would take the transmit counter past 255 sets bus-off and leaves the counter unchanged. While bus-off, all count events are ignored. A `recover_i` pulse during bus-off clears both counters and leaves bus-off. A `recover_i` pulse has no effect when the node is not bus-off.
- R6: A write with `reg_sel_i`=0 stores `reg_wdata_i` into the test-control word, and `test_reg_o` returns it. Bit 15 is the master enable. While bit 15 is 0, bits 14..0 have no effect.
- R7: With bit 15 and bit 11 set, both counters ignore all count events and keep their values.
- R8: With bit 15 and bit 13 set and the node not bus-off, the node reports error passive whatever the counter values are.
- R9: A write with `reg_sel_i`=1 loads `reg_wdata_i[15:8]` into both counters in the same cycle. The load happens only when bit 15 and bit 14 are set and `halt_i` is 1; otherwise the write is ignored. Because a loaded value is at most 255, a load never causes bus-off.
- R10: Exactly one of `err_active_o`, `err_passive_o` and `bus_off_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error event pulse |
| tx_ok_i | input | 1 | Successful transmission event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| rx_ok_i | input | 1 | Successful reception event pulse |
| recover_i | input | 1 | Bus-off recovery pulse |
| halt_i | input | 1 | Controller is in halt mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: test-control word, 1: counter load |
| reg_wdata_i | input | 16 | Register write data |
| test_reg_o | output | 16 | Test-control word readback |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| err_active_o | output | 1 | Node is error active |
| err_passive_o | output | 1 | Node is error passive |
| bus_off_o | output | 1 | Node is bus-off |
| warn_o | output | 1 | Error warning |

## Verification
The bench uses the default parameters: 8-bit counters, a transmit step of 8, and thresholds at 96 and 128. With these values the bench can reach every edge case in a few hundred event pulses. It steps the transmit counter exactly to 95, 127 and 255, one transmit error short of each threshold. It drives the receive counter into saturation at 255. It loads 255 into both counters to show that a load stops short of bus-off. With the master enable cleared, it shows that each override bit does nothing.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  // bit positions inside the test-control word
  localparam int TST_MASTER = 15;
  localparam int TST_WRCNT  = 14;
  localparam int TST_FPASS  = 13;
  localparam int TST_FREEZE = 11;

  typedef struct packed {
    logic wr_cnt;
    logic force_pass;
    logic freeze;
  } test_ctrl_t;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_test_reg.sv
module can_fc_test_reg
  import can_fc_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] reg_o,
  output test_ctrl_t       ctrl_o
);
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (we_i) reg_q <= wdata_i;
  end

  // override bits are live only under the master enable
  always_comb begin
    ctrl_o.wr_cnt     = reg_q[TST_MASTER] & reg_q[TST_WRCNT];
    ctrl_o.force_pass = reg_q[TST_MASTER] & reg_q[TST_FPASS];
    ctrl_o.freeze     = reg_q[TST_MASTER] & reg_q[TST_FREEZE];
  end

  assign reg_o = reg_q;
endmodule

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
  parameter int W   = 8,
  parameter int INC = 1,
  parameter bit SAT = 1'b1   // 1: saturate on overflow, 0: hold and flag
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W:0]   INC_X = (W+1)'(INC);
  localparam logic [W-1:0] CMAX  = '1;

  logic [W-1:0] cnt_q, cnt_d, inc_val;
  logic [W:0]   sum;

  assign sum   = {1'b0, cnt_q} + INC_X;
  assign ovf_o = sum[W];

  generate
    if (SAT) begin : g_sat
      assign inc_val = ovf_o ? CMAX : sum[W-1:0];
    end else begin : g_hold
      assign inc_val = ovf_o ? cnt_q : sum[W-1:0];
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                       cnt_d = '0;
    else if (load_i)                 cnt_d = load_val_i;
    else if (inc_i)                  cnt_d = inc_val;
    else if (dec_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int W          = 8,
  parameter int WARN_TH    = 96,
  parameter int PASSIVE_TH = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tec_i,
  input  logic [W-1:0] rec_i,
  input  logic         boff_set_i,
  input  logic         boff_clr_i,
  input  logic         force_pass_i,
  output fc_state_e    state_o,
  output logic         warn_o
);
  logic boff_q;
  logic over_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         boff_q <= 1'b0;
    else if (boff_clr_i) boff_q <= 1'b0;
    else if (boff_set_i) boff_q <= 1'b1;
  end

  assign over_pass = (int'(tec_i) >= PASSIVE_TH) || (int'(rec_i) >= PASSIVE_TH);
  assign warn_o    = (int'(tec_i) >= WARN_TH)    || (int'(rec_i) >= WARN_TH);

  always_comb begin
    if (boff_q)                         state_o = ST_BUSOFF;
    else if (over_pass || force_pass_i) state_o = ST_PASSIVE;
    else                                state_o = ST_ACTIVE;
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int REG_W      = 16,
  parameter int TX_ERR_INC = 8,
  parameter int RX_ERR_INC = 1,
  parameter int WARN_TH    = 96,
  parameter int PASSIVE_TH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_ok_i,
  input  logic             recover_i,
  input  logic             halt_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] test_reg_o,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             err_active_o,
  output logic             err_passive_o,
  output logic             bus_off_o,
  output logic             warn_o
);
  localparam int LOAD_LSB = REG_W - CNT_W;

  test_ctrl_t       ctrl;
  fc_state_e        state;
  logic             cnt_en, load, clr, tec_ovf;
  logic [CNT_W-1:0] load_val;

  can_fc_test_reg #(.REG_W(REG_W)) u_treg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i & ~reg_sel_i),
    .wdata_i (reg_wdata_i),
    .reg_o   (test_reg_o),
    .ctrl_o  (ctrl)
  );

  assign cnt_en   = ~ctrl.freeze & (state != ST_BUSOFF);
  assign load     = reg_we_i & reg_sel_i & ctrl.wr_cnt & halt_i;
  assign load_val = reg_wdata_i[REG_W-1:LOAD_LSB];
  assign clr      = recover_i & (state == ST_BUSOFF);

  can_fc_counter #(.W(CNT_W), .INC(TX_ERR_INC), .SAT(1'b0)) u_tec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .load_i     (load),
    .load_val_i (load_val),
    .inc_i      (tx_err_i & cnt_en),
    .dec_i      (tx_ok_i & cnt_en),
    .cnt_o      (tec_o),
    .ovf_o      (tec_ovf)
  );

  logic rec_ovf_unused;
  can_fc_counter #(.W(CNT_W), .INC(RX_ERR_INC), .SAT(1'b1)) u_rec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .load_i     (load),
    .load_val_i (load_val),
    .inc_i      (rx_err_i & cnt_en),
    .dec_i      (rx_ok_i & cnt_en),
    .cnt_o      (rec_o),
    .ovf_o      (rec_ovf_unused)
  );

  can_fc_state #(.W(CNT_W), .WARN_TH(WARN_TH), .PASSIVE_TH(PASSIVE_TH)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tec_i        (tec_o),
    .rec_i        (rec_o),
    .boff_set_i   (tx_err_i & cnt_en & tec_ovf & ~load),
    .boff_clr_i   (clr),
    .force_pass_i (ctrl.force_pass),
    .state_o      (state),
    .warn_o       (warn_o)
  );

  assign err_active_o  = (state == ST_ACTIVE);
  assign err_passive_o = (state == ST_PASSIVE);
  assign bus_off_o     = (state == ST_BUSOFF);
endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
  parameter int CNT_W      = 8,
  parameter int REG_W      = 16,
  parameter int WARN_TH    = 96,
  parameter int PASSIVE_TH = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_err_i,
  input logic             tx_ok_i,
  input logic             rx_err_i,
  input logic             rx_ok_i,
  input logic             recover_i,
  input logic             halt_i,
  input logic             reg_we_i,
  input logic             reg_sel_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] test_reg_o,
  input logic [CNT_W-1:0] tec_o,
  input logic [CNT_W-1:0] rec_o,
  input logic             err_active_o,
  input logic             err_passive_o,
  input logic             bus_off_o,
  input logic             warn_o
);
  logic load_ok, master;
  assign master  = test_reg_o[15];
  assign load_ok = reg_we_i & reg_sel_i & master & test_reg_o[14] & halt_i;

  // R10
  state_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({err_active_o, err_passive_o, bus_off_o}) == 1);

  // R3
  rec_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_o == '1 && !rx_ok_i && !load_ok && !recover_i) |=> rec_o == '1);

  // R7
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master && test_reg_o[11] && !load_ok && !recover_i) |=> ($stable(tec_o) && $stable(rec_o)));

  // R8
  force_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master && test_reg_o[13] && !bus_off_o) |-> err_passive_o);

  // R6
  passive_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_passive_o |-> (int'(tec_o) >= PASSIVE_TH || int'(rec_o) >= PASSIVE_TH
                       || (master && test_reg_o[13])));

  // R5
  recover_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && recover_i) |=> (tec_o == '0 && rec_o == '0 && !bus_off_o));

  // R5
  busoff_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && !recover_i) |=> bus_off_o);

  // R9
  load_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ok && !(bus_off_o && recover_i)) |=>
      (tec_o == $past(reg_wdata_i[REG_W-1 -: CNT_W]) && rec_o == tec_o));

  // R4
  warn_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o == (int'(tec_o) >= WARN_TH || int'(rec_o) >= WARN_TH));
endmodule

bind can_fault_conf can_fc_chk #(
  .CNT_W(CNT_W), .REG_W(REG_W), .WARN_TH(WARN_TH), .PASSIVE_TH(PASSIVE_TH)
) u_chk (.*);

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0, recover = 0, halt = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [15:0] wdata = '0;
  logic [15:0] treg;
  logic [7:0]  tec, rec;
  logic act, pas, boff, warn;
  int checks = 0, errors = 0;
  int exp_tec = 0, exp_rec = 0;

  always #2.5 clk = ~clk;

  can_fault_conf dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_err_i(tx_err), .tx_ok_i(tx_ok),
    .rx_err_i(rx_err), .rx_ok_i(rx_ok), .recover_i(recover), .halt_i(halt),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(wdata),
    .test_reg_o(treg), .tec_o(tec), .rec_o(rec), .err_active_o(act),
    .err_passive_o(pas), .bus_off_o(boff), .warn_o(warn)
  );

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // state code: 0 active, 1 passive, 2 bus-off
  task automatic chk_state(string req, int st, int w);
    chk({req, " state"}, {29'd0, boff, pas, act}, 1 << st);
    chk({req, " warn"}, int'(warn), w);
  endtask

  task automatic chk_cnt(string req);
    chk({req, " tec"}, int'(tec), exp_tec);
    chk({req, " rec"}, int'(rec), exp_rec);
  endtask

  // drive a one-cycle event pattern; outputs valid at the following negedge
  task automatic ev(bit te, bit to, bit re, bit ro, int n = 1);
    for (int i = 0; i < n; i++) begin
      tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro;
      @(negedge clk);
      tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0;
    end
  endtask

  task automatic wr(bit sel, logic [15:0] d);
    reg_we = 1; reg_sel = sel; wdata = d;
    @(negedge clk);
    reg_we = 0; reg_sel = 0; wdata = '0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 tec", int'(tec), 0);
    chk("R1 rec", int'(rec), 0);
    chk("R1 treg", int'(treg), 0);
    chk_state("R1", 0, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic t_tx_count;
    ev(0, 1, 0, 1); chk_cnt("R2 R3 floor at 0");
    ev(1, 0, 0, 0, 3); exp_tec = 24; chk_cnt("R2 inc by 8");
    ev(0, 1, 0, 0); exp_tec = 23; chk_cnt("R2 dec by 1");
    ev(1, 1, 0, 0); exp_tec = 31; chk_cnt("R2 error wins");
    ev(0, 0, 1, 0, 10); exp_rec = 10; chk_cnt("R3 inc by 1");
    ev(0, 0, 1, 1); exp_rec = 11; chk_cnt("R3 error wins");
    ev(0, 0, 0, 1, 2); exp_rec = 9; chk_cnt("R3 dec");
  endtask

  task automatic t_thresholds;
    ev(1, 0, 0, 0, 8); exp_tec = 95; chk_cnt("R4 95"); chk_state("R4 below warn", 0, 0);
    ev(1, 0, 0, 0); exp_tec = 103; chk_state("R4 warn at 103", 0, 1);
    ev(1, 0, 0, 0, 3); exp_tec = 127; chk_cnt("R4 127"); chk_state("R4 127 active", 0, 1);
    ev(1, 0, 0, 0); exp_tec = 135; chk_state("R4 passive at 135", 1, 1);
    ev(0, 1, 0, 0, 8); exp_tec = 127; chk_state("R4 back to active", 0, 1);
  endtask

  task automatic t_rx_sat;
    ev(0, 0, 1, 0, 300); exp_rec = 255; chk_cnt("R3 saturate"); chk_state("R4 rec passive", 1, 1);
    ev(0, 0, 0, 1); exp_rec = 254; chk_cnt("R3 dec from sat");
  endtask

  task automatic t_busoff;
    recover = 1; @(negedge clk); recover = 0;
    chk_cnt("R5 recover ignored when not bus-off");
    ev(1, 0, 0, 0, 16); exp_tec = 255; chk_cnt("R5 at 255"); chk_state("R5 not yet bus-off", 1, 1);
    ev(1, 0, 0, 0); chk_cnt("R5 tec held"); chk_state("R5 bus-off", 2, 1);
    ev(0, 1, 0, 1, 3); chk_cnt("R5 events ignored");
    recover = 1; @(negedge clk); recover = 0;
    exp_tec = 0; exp_rec = 0; chk_cnt("R5 recover clears"); chk_state("R5 active", 0, 0);
  endtask

  task automatic t_master_off;
    wr(0, 16'h7FFF); chk("R6 readback", int'(treg), 16'h7FFF);
    chk_state("R6 no force", 0, 0);
    ev(1, 0, 1, 0); exp_tec = 8; exp_rec = 1; chk_cnt("R6 no freeze");
    halt = 1; wr(1, 16'hAB00); halt = 0; chk_cnt("R6 no load");
  endtask

  task automatic t_freeze;
    wr(0, 16'h8800);
    ev(1, 0, 1, 0, 2); chk_cnt("R7 frozen");
    ev(0, 1, 0, 1); chk_cnt("R7 frozen dec");
    wr(0, 16'h0000);
    ev(1, 0, 0, 0); exp_tec = 16; chk_cnt("R7 unfrozen");
  endtask

  task automatic t_force_pass;
    wr(0, 16'hA000); chk_state("R8 forced passive", 1, 0); chk_cnt("R8 counters kept");
    wr(0, 16'h0000); chk_state("R8 released", 0, 0);
  endtask

  task automatic t_cnt_write;
    wr(0, 16'hC000);
    wr(1, 16'h5A33); chk_cnt("R9 no halt ignored");
    halt = 1;
    wr(1, 16'h5A33); exp_tec = 90; exp_rec = 90; chk_cnt("R9 load both");
    wr(1, 16'hFF00); exp_tec = 255; exp_rec = 255; chk_cnt("R9 load 255");
    chk_state("R9 no bus-off", 1, 1);
    wr(0, 16'h4000);
    wr(1, 16'h1200); chk_cnt("R9 no master ignored");
    wr(0, 16'h8000);
    wr(1, 16'h1200); chk_cnt("R9 no write bit ignored");
    halt = 0;
  endtask

  initial begin
    t_reset;
    t_tx_count;
    t_thresholds;
    t_rx_sat;
    t_busoff;
    t_master_off;
    t_freeze;
    t_force_pass;
    t_cnt_write;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule